// File: doc/BRIEF.md
# Selectable Quadrature Encoder Counter

This block turns two quadrature channels, A and B, into a position count. A two-bit mode input picks the counting scheme at run time: count on the edges of A alone, on the edges of B alone, or on the edges of both channels. Each accepted edge moves the count by one. The level of the channel that did not toggle decides whether the step goes up or down. Both channels pass through a two-stage synchroniser before their edges are detected, so they may come from outside the clock domain. The inputs must already be filtered.

When the encoder schemes are off, the block works as a plain up-counter. It advances once per clock in which an internal tick enable is high, but only while a counter-enable bit is set. The count runs between 0 and a run-time auto-reload value. Going past either end wraps the count and raises a one-cycle wrap pulse. A direction flag reports the sign of the most recent step, so software or a neighbouring block can tell forward motion from reverse.

Top module: `quad_step_counter`

## Requirements
- R1: After reset the count is 0, the direction flag is 0 (up) and the wrap pulse is 0.
- R2: With mode code 1, each edge of A is one step and edges of B alone cause none. The step is up when A rises with B low or A falls with B high, and down for the other two cases.
- R3: With mode code 2, each edge of B is one step and edges of A alone cause none. The step is up when B rises with A high or B falls with A low, and down for the other two cases.
- R4: With mode code 3, edges of both channels step the count with the direction rules of R2 and R3, so one full quadrature cycle gives four steps.
- R5: With mode code 0, the count rises by one for every clock in which both the tick enable and the counter enable are 1, and channel edges cause no step.
- R6: With mode code 0 and the counter enable at 0, tick pulses leave the count and the direction flag unchanged.
- R7: An up step taken when the count equals or exceeds the auto-reload value loads 0 and raises the wrap pulse for exactly one cycle.
- R8: A down step taken at count 0 loads the auto-reload value and raises the wrap pulse for exactly one cycle.
- R9: The direction flag becomes 0 after an up step and 1 after a down step, and it holds its value in cycles without a step.
- R10: When both channels are seen to change in the same synchronised sample, no step is taken in any encoder mode.
- R11: The count changes by at most one step per clock and stays the same in every cycle without an accepted step. A channel change driven before a clock edge is counted on the third rising edge from that edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chanA | input | 1 | Quadrature channel A, filtered |
| chanB | input | 1 | Quadrature channel B, filtered |
| modeSel | input | 2 | 0 tick counting, 1 edges of A, 2 edges of B, 3 edges of both |
| cntEnable | input | 1 | Allows tick counting in mode 0 |
| tickEn | input | 1 | Internal tick, one step per high cycle in mode 0 |
| autoReload | input | CNT_W | Upper limit of the count |
| count | output | CNT_W | Current count |
| dirDown | output | 1 | 1 when the most recent step was down |
| wrapPulse | output | 1 | One-cycle pulse when the count wraps at either end |

## Verification
The embedded properties check several rules on every clock. A step is never both up and down. Coincident edges on both channels and gated-off ticks produce no step. Wrap at the top goes to 0, and underflow at 0 loads the auto-reload value. The direction flag follows each step, and the count holds between steps. These properties cannot show that the phase-to-direction mapping and the choice of counting channel are correct for each mode. Those are shown by the bench scenarios: full forward and reverse quadrature cycles, random channel toggles and mode switches, and tick runs with the enable in both states, all compared with a model of the requirements.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [1:0] {
    MODE_TICK   = 2'd0,
    MODE_EDGE_A = 2'd1,
    MODE_EDGE_B = 2'd2,
    MODE_BOTH   = 2'd3
  } cntMode_t;

  typedef struct packed {
    logic up;
    logic down;
  } stepCmd_t;

endpackage

// File: rtl/qenc_ctrl.sv
module qenc_ctrl
  import qenc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chanA,
  input  logic       chanB,
  input  logic [1:0] modeSel,
  input  logic       cntEnable,
  input  logic       tickEn,
  output stepCmd_t   stepCmd
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] shiftA, shiftB;
  logic          prevA, prevB;
  logic          levA, levB;
  logic          edgeA, edgeB;
  logic          takeA, takeB;
  cntMode_t      mode;

  // Two-flop (or deeper) synchroniser chain per channel.
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          shiftA <= '0;
          shiftB <= '0;
        end else begin
          shiftA <= {shiftA[LAST-1:0], chanA};
          shiftB <= {shiftB[LAST-1:0], chanB};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          shiftA <= '0;
          shiftB <= '0;
        end else begin
          shiftA <= chanA;
          shiftB <= chanB;
        end
      end
    end
  endgenerate

  assign levA = shiftA[LAST];
  assign levB = shiftB[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA <= 1'b0;
      prevB <= 1'b0;
    end else begin
      prevA <= levA;
      prevB <= levB;
    end
  end

  assign edgeA = levA ^ prevA;
  assign edgeB = levB ^ prevB;
  assign mode  = cntMode_t'(modeSel);

  always_comb begin
    takeA = 1'b0;
    takeB = 1'b0;
    case (mode)
      MODE_EDGE_A: takeA = edgeA && !edgeB;
      MODE_EDGE_B: takeB = edgeB && !edgeA;
      MODE_BOTH: begin
        takeA = edgeA && !edgeB;
        takeB = edgeB && !edgeA;
      end
      default: ;
    endcase
  end

  always_comb begin
    stepCmd = '0;
    if (mode == MODE_TICK) begin
      stepCmd.up = tickEn && cntEnable;
    end else if (takeA) begin
      // A leads B when the levels differ after an A edge.
      stepCmd.up   = levA ^ levB;
      stepCmd.down = !(levA ^ levB);
    end else if (takeB) begin
      stepCmd.up   = !(levA ^ levB);
      stepCmd.down = levA ^ levB;
    end
  end

  a_r11_single_step: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stepCmd.up, stepCmd.down}));

  a_r10_dual_edge_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != 2'd0 && edgeA && edgeB) |-> !stepCmd.up && !stepCmd.down);

  a_r6_gated_tick: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'd0 && !cntEnable) |-> !stepCmd.up && !stepCmd.down);

endmodule

// File: rtl/qenc_datapath.sv
module qenc_datapath
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepCmd_t         stepCmd,
  input  logic [CNT_W-1:0] autoReload,
  output logic [CNT_W-1:0] count,
  output logic             dirDown,
  output logic             wrapPulse
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic atTop, atBottom;

  assign atTop    = count >= autoReload;
  assign atBottom = count == ZERO;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= ZERO;
      dirDown   <= 1'b0;
      wrapPulse <= 1'b0;
    end else begin
      wrapPulse <= 1'b0;
      if (stepCmd.up) begin
        dirDown <= 1'b0;
        if (atTop) begin
          count     <= ZERO;
          wrapPulse <= 1'b1;
        end else begin
          count <= count + ONE;
        end
      end else if (stepCmd.down) begin
        dirDown <= 1'b1;
        if (atBottom) begin
          count     <= autoReload;
          wrapPulse <= 1'b1;
        end else begin
          count <= count - ONE;
        end
      end
    end
  end

  a_r7_top_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (stepCmd.up && count >= autoReload) |=> count == ZERO && wrapPulse);

  a_r8_bottom_reload: assert property (@(posedge clk) disable iff (!rstN)
    (stepCmd.down && count == ZERO) |=> count == $past(autoReload) && wrapPulse);

  a_r9_dir_up: assert property (@(posedge clk) disable iff (!rstN)
    stepCmd.up |=> !dirDown);

  a_r9_dir_down: assert property (@(posedge clk) disable iff (!rstN)
    stepCmd.down |=> dirDown);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stepCmd.up && !stepCmd.down) |=> $stable(count) && $stable(dirDown) && !wrapPulse);

endmodule

// File: rtl/quad_step_counter.sv
module quad_step_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanA,
  input  logic             chanB,
  input  logic [1:0]       modeSel,
  input  logic             cntEnable,
  input  logic             tickEn,
  input  logic [CNT_W-1:0] autoReload,
  output logic [CNT_W-1:0] count,
  output logic             dirDown,
  output logic             wrapPulse
);

  stepCmd_t stepCmd;

  qenc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .chanA     (chanA),
    .chanB     (chanB),
    .modeSel   (modeSel),
    .cntEnable (cntEnable),
    .tickEn    (tickEn),
    .stepCmd   (stepCmd)
  );

  qenc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stepCmd    (stepCmd),
    .autoReload (autoReload),
    .count      (count),
    .dirDown    (dirDown),
    .wrapPulse  (wrapPulse)
  );

endmodule

// File: tb/sim_quad_step_counter.sv
`timescale 1ns/1ps
module sim_quad_step_counter;

  localparam int CNT_W = 16;
  localparam logic [CNT_W-1:0] ARR = 16'd11;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             chanA = 1'b0, chanB = 1'b0;
  logic [1:0]       modeSel = 2'd0;
  logic             cntEnable = 1'b0, tickEn = 1'b0;
  logic [CNT_W-1:0] autoReload = ARR;
  logic [CNT_W-1:0] count;
  logic             dirDown, wrapPulse;

  int tests = 0, fails = 0;
  int expCount = 0, expWraps = 0, seenWraps = 0;
  logic expDir = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  quad_step_counter #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .chanA(chanA), .chanB(chanB), .modeSel(modeSel),
    .cntEnable(cntEnable), .tickEn(tickEn), .autoReload(autoReload),
    .count(count), .dirDown(dirDown), .wrapPulse(wrapPulse)
  );

  always @(negedge clk) if (rstN && wrapPulse) seenWraps++;

  function automatic int stepOf(input logic [1:0] m, input logic oa, ob, na, nb,
                                input logic tk, en);
    logic ca, cb;
    ca = oa != na;
    cb = ob != nb;
    if (m == 2'd0) return (tk && en) ? 1 : 0;
    if (ca && cb) return 0;
    if (ca && (m == 2'd1 || m == 2'd3)) return (na ^ nb) ? 1 : -1;
    if (cb && (m == 2'd2 || m == 2'd3)) return (na ^ nb) ? -1 : 1;
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic applyModel(input int st);
    if (st == 1) begin
      expDir = 1'b0;
      if (expCount >= int'(ARR)) begin expCount = 0; expWraps++; end
      else expCount++;
    end else if (st == -1) begin
      expDir = 1'b1;
      if (expCount == 0) begin expCount = int'(ARR); expWraps++; end
      else expCount--;
    end
  endtask

  // Drive new channel levels and an optional one-cycle tick, then settle.
  task automatic drive(input string req, input logic na, nb, tk);
    int st;
    st = stepOf(modeSel, chanA, chanB, na, nb, tk, cntEnable);
    @(negedge clk);
    chanA = na; chanB = nb; tickEn = tk;
    @(negedge clk);
    tickEn = 1'b0;
    repeat (3) @(negedge clk);
    applyModel(st);
    check(req, int'(count), expCount);
    check(req, int'(dirDown), int'(expDir));
    check(req, seenWraps, expWraps);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", int'(count), 0);
    check("R1", int'(dirDown), 0);
    check("R1", int'(wrapPulse), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R4: full forward cycle, then reverse, in mode 3.
    modeSel = 2'd3;
    drive("R4", 1, 0, 0); drive("R4", 1, 1, 0);
    drive("R4", 0, 1, 0); drive("R4", 0, 0, 0);
    check("R4", int'(count), 4);
    drive("R4", 0, 1, 0); drive("R4", 1, 1, 0);
    drive("R4", 1, 0, 0); drive("R4", 0, 0, 0);
    check("R4", int'(count), 0);
    // R8: down from 0 reloads; R7: up from top wraps to 0.
    drive("R8", 0, 1, 0);
    check("R8", int'(count), int'(ARR));
    drive("R7", 0, 0, 0);
    check("R7", int'(count), 0);
    // R10: both channels change together.
    drive("R10", 1, 1, 0);
    drive("R10", 0, 0, 0);
    // R2: mode 1, B edges ignored.
    modeSel = 2'd1;
    drive("R2", 0, 1, 0); drive("R2", 1, 1, 0); drive("R2", 1, 0, 0);
    // R3: mode 2, A edges ignored.
    modeSel = 2'd2;
    drive("R3", 0, 0, 0); drive("R3", 0, 1, 0); drive("R3", 1, 1, 0);
    // R5 / R6: tick mode.
    modeSel = 2'd0; cntEnable = 1'b1;
    drive("R5", 1, 1, 1); drive("R5", 0, 1, 1);
    cntEnable = 1'b0;
    drive("R6", 0, 1, 1); drive("R6", 0, 0, 1);

    // Random mix of modes, toggles and ticks.
    for (int i = 0; i < 400; i++) begin
      int pick;
      logic na, nb;
      if ($urandom_range(0, 7) == 0) modeSel = 2'($urandom_range(0, 3));
      cntEnable = 1'($urandom_range(0, 1));
      pick = $urandom_range(0, 5);
      na = chanA; nb = chanB;
      if (pick <= 1) na = !chanA;
      else if (pick <= 3) nb = !chanB;
      else if (pick == 4) begin na = !chanA; nb = !chanB; end
      drive("R9", na, nb, 1'($urandom_range(0, 1)));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R11 watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule